// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block turns a 25-bit logical address into a 22-bit physical RAM address through an inverted page table. The table has one entry for each of the 128 physical pages. Each entry records two things: the logical page that its physical page currently stands for, and a two-bit protection level. On each lookup, the logical page number of the incoming address is compared against every entry at once. The physical page number is then recovered from the bits of the matching entry. How those bits are rearranged depends on the selected page size, which may be 4, 8, 16 or 32 KB.

Entries are loaded by presenting a full address word on the write port. The low bits of that word pick the entry, and the remaining bits carry the logical page and the protection level. A lookup is checked against the access mode and direction. The mode is supervisor, OS or user, and is derived from the translate flag and the OS mode flag. When no entry matches, or the access is not allowed, the block raises abort. The lookup path is combinational and the table is clocked. The RAM itself lies outside this block.

Top module: `ipt_translator`

## Requirements
- R1: After reset every entry holds zero. Logical page 0 then maps to physical page 0 with full rights, and every other logical page aborts.
- R2: A write with `wr_en` high stores `wr_word[22:0]` into the entry indexed by `wr_word[6:0]`, replacing that entry. A lookup in the same cycle as the write still sees the old contents. The new contents apply from the next cycle.
- R3: With `pg_size`=00 (4 KB), the entry's logical page is {E[11:10],E[22:12]} and its physical page is E[6:0]. The logical page is taken from laddr[24:12] and the offset from laddr[11:0].
- R4: With `pg_size`=01 (8 KB), the logical page is {E[11:10],E[22:13]} and the physical page is {E[0],E[6:1]}. The offset is laddr[12:0].
- R5: With `pg_size`=10 (16 KB), the logical page is {E[11:10],E[22:14]} and the physical page is {E[1:0],E[6:2]}. The offset is laddr[13:0].
- R6: With `pg_size`=11 (32 KB), the logical page is {E[11:10],E[22:15]}. The physical page bits are: bit 6 = E[1], bit 5 = E[2], bit 4 = E[0], bits 3..0 = E[6:3]. The offset is laddr[14:0].
- R7: The access mode is supervisor when `xlat`=0, OS when `xlat`=1 and `os_mode`=1, and user when `xlat`=1 and `os_mode`=0. Supervisor may read and write any matched page.
- R8: Entry bits [9:8] set the rights. With 00, OS and user may both read and write. With 01, OS may read and write and user may only read. With 10 or 11, OS may only read and user has no access.
- R9: `abort` is high when no entry matches or when the access is denied. While `abort` is high, `paddr` is zero. `hit` shows whether any entry matched.
- R10: When several entries hold the same logical page, the entry with the lowest index supplies both the physical page and the rights.
- R11: The physical address is the physical page placed above the offset. When `word_acc`=1, bits [1:0] of the result are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all entries |
| wr_en | input | 1 | Load one table entry this cycle |
| wr_word | input | 25 | Entry word; bits [6:0] select the entry |
| pg_size | input | 2 | Page size: 00=4 KB, 01=8 KB, 10=16 KB, 11=32 KB |
| os_mode | input | 1 | OS mode flag |
| xlat | input | 1 | Translate flag (0 selects supervisor) |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| word_acc | input | 1 | Word access; clears physical address bits [1:0] |
| laddr | input | 25 | Logical address |
| paddr | output | 22 | Physical RAM address, zero on abort |
| abort | output | 1 | Miss or protection violation |
| hit | output | 1 | Some entry matched the logical page |

## Verification
Loading an entry and looking up through the table can happen in the same clock cycle. The bench provokes this by raising `wr_en` with a fresh mapping for a logical page while presenting that same page as the lookup address. The scoreboard expects an abort in that cycle, because the lookup reads the old table contents. On the next cycle, with the write port idle, it expects the new physical address. A later rewrite of the same entry index is also checked, and the old mapping must be gone afterwards.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;
  localparam int LADDR_W = 25;
  localparam int PADDR_W = 22;
  localparam int ENTRY_W = 23;
  localparam int PPN_W   = 7;
  localparam int LPN_W   = 13;

  typedef enum logic [1:0] {PG4K = 2'b00, PG8K = 2'b01, PG16K = 2'b10, PG32K = 2'b11} pg_size_e;

  // logical page number an entry claims, for the given page size
  function automatic logic [LPN_W-1:0] entry_lpn(input logic [ENTRY_W-1:0] e, input pg_size_e s);
    case (s)
      PG4K:    entry_lpn = {e[11:10], e[22:12]};
      PG8K:    entry_lpn = {1'b0, e[11:10], e[22:13]};
      PG16K:   entry_lpn = {2'b0, e[11:10], e[22:14]};
      default: entry_lpn = {3'b0, e[11:10], e[22:15]};
    endcase
  endfunction

  // physical page number, with the size-dependent bit rearrangement
  function automatic logic [PPN_W-1:0] entry_ppn(input logic [ENTRY_W-1:0] e, input pg_size_e s);
    case (s)
      PG4K:    entry_ppn = e[6:0];
      PG8K:    entry_ppn = {e[0], e[6:1]};
      PG16K:   entry_ppn = {e[1:0], e[6:2]};
      default: entry_ppn = {e[1], e[2], e[0], e[6:3]};
    endcase
  endfunction

  // logical page number of an incoming address
  function automatic logic [LPN_W-1:0] addr_lpn(input logic [LADDR_W-1:0] a, input pg_size_e s);
    case (s)
      PG4K:    addr_lpn = a[24:12];
      PG8K:    addr_lpn = {1'b0, a[24:13]};
      PG16K:   addr_lpn = {2'b0, a[24:14]};
      default: addr_lpn = {3'b0, a[24:15]};
    endcase
  endfunction
endpackage

// File: rtl/ipt_table.sv
`timescale 1ns/1ps
module ipt_table #(
  parameter int N_ENT   = 128,
  parameter int ENTRY_W = 23,
  parameter int WORD_W  = 25,
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [WORD_W-1:0]               wr_word,
  output logic [N_ENT-1:0][ENTRY_W-1:0]   ent
);
  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_word[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ent <= '0;
    end else if (wr_en) begin
      ent[wr_idx] <= wr_word[ENTRY_W-1:0];
    end
  end
endmodule

// File: rtl/ipt_match.sv
`timescale 1ns/1ps
module ipt_match
  import ipt_pkg::*;
#(
  parameter int N_ENT = 128
) (
  input  logic [N_ENT-1:0][ENTRY_W-1:0] ent,
  input  pg_size_e                      size,
  input  logic [LPN_W-1:0]              want_lpn,
  output logic [N_ENT-1:0]              match
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign match[i] = (entry_lpn(ent[i], size) == want_lpn);
  end
endmodule

// File: rtl/ipt_pick.sv
`timescale 1ns/1ps
module ipt_pick
  import ipt_pkg::*;
#(
  parameter int N_ENT = 128
) (
  input  logic [N_ENT-1:0][ENTRY_W-1:0] ent,
  input  logic [N_ENT-1:0]              match,
  output logic                          any,
  output logic [ENTRY_W-1:0]            sel
);
  // scan downward so the lowest matching index is assigned last
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        sel = ent[i];
      end
    end
  end
endmodule

// File: rtl/ipt_rights.sv
`timescale 1ns/1ps
module ipt_rights (
  input  logic       xlat,
  input  logic       os_mode,
  input  logic       is_write,
  input  logic [1:0] prot,
  output logic       ok
);
  always_comb begin
    if (!xlat) begin
      ok = 1'b1;
    end else if (os_mode) begin
      ok = !is_write || !prot[1];
    end else begin
      case (prot)
        2'b00:   ok = 1'b1;
        2'b01:   ok = !is_write;
        default: ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ipt_translator.sv
`timescale 1ns/1ps
module ipt_translator
  import ipt_pkg::*;
#(
  parameter int N_ENT = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [24:0]        wr_word,
  input  logic [1:0]         pg_size,
  input  logic               os_mode,
  input  logic               xlat,
  input  logic               is_write,
  input  logic               word_acc,
  input  logic [24:0]        laddr,
  output logic [21:0]        paddr,
  output logic               abort,
  output logic               hit
);
  pg_size_e                      size;
  logic [N_ENT-1:0][ENTRY_W-1:0] tbl;
  logic [N_ENT-1:0]              match;
  logic [ENTRY_W-1:0]            sel_ent;
  logic [1:0]                    sel_prot;
  logic [LPN_W-1:0]              want_lpn;
  logic [PPN_W-1:0]              ppn;
  logic                          rights_ok;
  logic [PADDR_W-1:0]            joined;

  assign size     = pg_size_e'(pg_size);
  assign want_lpn = addr_lpn(laddr, size);

  ipt_table #(.N_ENT(N_ENT), .ENTRY_W(ENTRY_W), .WORD_W(LADDR_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .ent(tbl)
  );

  ipt_match #(.N_ENT(N_ENT)) u_match (
    .ent(tbl), .size(size), .want_lpn(want_lpn), .match(match)
  );

  ipt_pick #(.N_ENT(N_ENT)) u_pick (
    .ent(tbl), .match(match), .any(hit), .sel(sel_ent)
  );

  assign sel_prot = sel_ent[9:8];
  assign ppn      = entry_ppn(sel_ent, size);

  ipt_rights u_rights (
    .xlat(xlat), .os_mode(os_mode), .is_write(is_write), .prot(sel_prot), .ok(rights_ok)
  );

  always_comb begin
    case (size)
      PG4K:    joined = {3'b0, ppn, laddr[11:0]};
      PG8K:    joined = {2'b0, ppn, laddr[12:0]};
      PG16K:   joined = {1'b0, ppn, laddr[13:0]};
      default: joined = {ppn, laddr[14:0]};
    endcase
    if (word_acc) joined[1:0] = 2'b00;
  end

  assign abort = !hit || !rights_ok;
  assign paddr = abort ? '0 : joined;
endmodule

// File: rtl/ipt_translator_chk.sv
`timescale 1ns/1ps
module ipt_translator_chk #(
  parameter int N_ENT = 128
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [24:0]              wr_word,
  input logic [1:0]               pg_size,
  input logic                     os_mode,
  input logic                     xlat,
  input logic                     is_write,
  input logic                     word_acc,
  input logic [24:0]              laddr,
  input logic [21:0]              paddr,
  input logic                     abort,
  input logic                     hit,
  input logic [1:0]               sel_prot,
  input logic [N_ENT-1:0][22:0]   tbl
);
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tbl[$past(wr_word[6:0])] == $past(wr_word[22:0]));

  p_super_full_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && !xlat) |-> !abort);

  p_user_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && xlat && !os_mode && is_write && sel_prot != 2'b00) |-> abort);

  p_os_read_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && xlat && os_mode && !is_write) |-> !abort);

  p_miss_abort_r9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> abort);

  p_abort_zero_r9: assert property (@(posedge clk) disable iff (rst)
    abort |-> paddr == '0);

  p_offset_4k_r3: assert property (@(posedge clk) disable iff (rst)
    (!abort && pg_size == 2'b00) |-> paddr[11:2] == laddr[11:2]);

  p_word_align_r11: assert property (@(posedge clk) disable iff (rst)
    word_acc |-> paddr[1:0] == 2'b00);
endmodule

bind ipt_translator ipt_translator_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pg_size(pg_size),
  .os_mode(os_mode), .xlat(xlat), .is_write(is_write), .word_acc(word_acc),
  .laddr(laddr), .paddr(paddr), .abort(abort), .hit(hit),
  .sel_prot(sel_prot), .tbl(tbl)
);

// File: tb/test_ipt_translator.sv
`timescale 1ns/1ps
module test_ipt_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [24:0] wr_word = '0;
  logic [1:0]  pg_size = 2'b00;
  logic        os_mode = 1'b0;
  logic        xlat = 1'b0;
  logic        is_write = 1'b0;
  logic        word_acc = 1'b0;
  logic [24:0] laddr = '0;
  logic [21:0] paddr;
  logic        abort;
  logic        hit;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        ab;
    logic [21:0] pa;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  ipt_translator i_ipt_translator (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pg_size(pg_size),
    .os_mode(os_mode), .xlat(xlat), .is_write(is_write), .word_acc(word_acc),
    .laddr(laddr), .paddr(paddr), .abort(abort), .hit(hit)
  );

  // monitor: compares in the middle of the cycle the driver set up
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (abort !== e.ab || paddr !== e.pa) begin
        n_errors++;
        $display("FAIL %s: abort=%0b paddr=%06h expected abort=%0b paddr=%06h",
                 e.tag, abort, paddr, e.ab, e.pa);
      end
    end
  end

  // one cycle: optional entry write plus optional checked lookup
  task automatic step(input bit we, input logic [24:0] ww,
                      input logic [24:0] la, input logic [1:0] sz,
                      input bit osm, input bit xl, input bit wrt, input bit wacc,
                      input bit chk, input logic eab, input logic [21:0] epa,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    wr_en = we; wr_word = ww;
    laddr = la; pg_size = sz; os_mode = osm; xlat = xl; is_write = wrt; word_acc = wacc;
    if (chk) begin
      e.ab = eab; e.pa = epa; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic load(input logic [24:0] w);
    step(1'b1, w, 25'h0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h0, "");
  endtask

  task automatic look(input logic [24:0] la, input logic [1:0] sz, input bit osm,
                      input bit xl, input bit wrt, input bit wacc,
                      input logic eab, input logic [21:0] epa, input string tag);
    step(1'b0, 25'h0, la, sz, osm, xl, wrt, wacc, 1'b1, eab, epa, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: zeroed table maps page 0 onto page 0, others miss
    look(25'h000456, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h000456, "R1 page0 after reset");
    look(25'h000456, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 22'h000456, "R1 page0 user write");
    look(25'h001000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, "R1 R9 page1 misses");

    // R3 / R11: 4 KB, ppn 0x15, lpn 0xA37, prot 00
    load(25'h237415);
    look(25'hA37ABF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h015ABF, "R3 4K byte");
    look(25'hA37ABF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 22'h015ABC, "R11 4K word align");
    look(25'hA37ABC, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 22'h015ABC, "R8 prot00 user write");

    // R7 / R8: prot 01 on lpn 5 -> ppn 0x22
    load(25'h005122);
    look(25'h005010, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 22'h022010, "R8 prot01 user read");
    look(25'h005010, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 22'h0, "R8 prot01 user write denied");
    look(25'h005010, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 22'h022010, "R8 prot01 os write");
    look(25'h005010, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 22'h022010, "R7 os_mode ignored without xlat");

    // prot 10 on lpn 6 -> ppn 0x30
    load(25'h006230);
    look(25'h006000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 22'h030000, "R8 prot10 os read");
    look(25'h006000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 22'h0, "R8 prot10 os write denied");
    look(25'h006000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, "R8 prot10 user read denied");
    look(25'h006000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 22'h030000, "R7 supervisor write prot10");

    // prot 11 on lpn 7 -> ppn 0x31
    load(25'h007331);
    look(25'h007000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, "R8 prot11 user read denied");
    look(25'h007000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 22'h031000, "R8 prot11 os read");

    // R4: 8 KB, index 0x23 -> ppn 0x51, lpn 0x955
    load(25'h2AA823);
    look(25'h12AB234, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h0A3234, "R4 8K lookup");

    // R5: 16 KB, index 0x4E -> ppn 0x53, lpn 0x6AB
    load(25'h2ACC4E);
    look(25'h1AAFFFD, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h14FFFD, "R5 16K lookup");
    look(25'h1AAFFFD, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 22'h14FFFC, "R5 R11 16K word");

    // R6: 32 KB, index 0x35 -> ppn 0x36, lpn 0x25A
    load(25'h2D0835);
    look(25'h12D7ABC, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h1B7ABC, "R6 32K lookup");

    // R10: entries 5 (prot 10) and 9 (prot 00) both claim lpn 0x40
    load(25'h040205);
    load(25'h040009);
    look(25'h040123, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, "R10 low index rights win");
    look(25'h040123, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h005123, "R10 low index ppn wins");

    // R2: write and lookup of the same page in one cycle
    step(1'b1, 25'h041060, 25'h041000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0,
         1'b1, 1'b1, 22'h0, "R2 same-cycle sees old table");
    look(25'h041000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h060000, "R2 next cycle sees new entry");
    load(25'h042060);
    look(25'h041000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, "R2 rewrite drops old mapping");
    look(25'h042000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h060000, "R2 rewrite new mapping");

    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule